// File: doc/BRIEF.md
# Selectable-Source Binary/Decade Counter

This block is a 4-bit up-counter that runs entirely on one system clock. It does not switch between clocks. It takes four single-cycle tick inputs, and a 2-bit select input decides which of them is allowed to advance the count. All four ticks must already be synchronous to the system clock.

A mode input sets where the count wraps. In binary mode the count runs from 0 to 15 and then returns to 0. In decade mode the count is cleared synchronously once it reaches nine, so it runs from 0 to 9. A terminal flag marks the last value of the current mode. Select and mode are sampled in every cycle, so a change applies from the next tick that qualifies.

Each cycle, the counter's next-state logic picks one of four named actions:
- `ACT_HOLD`: no qualifying tick, so the count stays as it is.
- `ACT_STEP`: the count increments.
- `ACT_WRAP`: the count sits on the last value of its mode and returns to 0.
- `ACT_CLEAR`: the counter is in decade mode with a count above nine, which can happen after a mode switch, and the count loads 0.

Synchronous reset overrides all four actions.

Top module: `sel_bd_counter`

## Requirements
- R1: While `rst` is high at a rising clock edge, `count` is 0 after that edge, whatever the tick, select and mode inputs are.
- R2: The `src_sel` encoding is 00 = `src_tick[0]`, 01 = `src_tick[1]`, 10 = `src_tick[2]`, 11 = `src_tick[3]`. Only the selected tick can advance the count. Ticks on sources that are not selected are ignored.
- R3: In a cycle where the selected tick is low, `count` keeps its value.
- R4: With `bin_mode` = 1 and a qualifying tick, `count` increments by one. If `count` is 15, it becomes 0 instead.
- R5: With `bin_mode` = 0 and a qualifying tick, `count` increments by one while it is below 9. If `count` is 9, it becomes 0 instead.
- R6: With `bin_mode` = 0 and a count above 9, such as after a switch from binary mode, the next qualifying tick loads 0.
- R7: `terminal` is high exactly when (`bin_mode` = 1 and `count` = 15) or (`bin_mode` = 0 and `count` = 9). It follows the present inputs and count with no register delay.
- R8: A change on `src_sel` or `bin_mode` applies to the same clock edge at which the new value is present. No extra cycle of delay is added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| src_tick | input | 4 | Count-enable ticks of the four sources |
| src_sel | input | 2 | Selects the tick that advances the count |
| bin_mode | input | 1 | 1 = modulo-16 counting, 0 = modulo-10 counting |
| count | output | 4 | Current count value |
| terminal | output | 1 | High on the last value of the current mode |

## Verification
The count responds one clock edge after its stimulus: ticks, select, mode and reset present before a rising edge decide the count that can be seen after that edge. The terminal flag depends on the current mode and count within the same cycle. The bench therefore drives inputs and compares `count` at the falling edge, where the count reflects everything up to the previous rising edge. It checks `terminal` one time step after the new inputs settle, against a reference model that is advanced only after both comparisons.

// File: rtl/sel_bd_counter_pkg.sv
package sel_bd_counter_pkg;

    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_STEP  = 2'd1,
        ACT_WRAP  = 2'd2,
        ACT_CLEAR = 2'd3
    } step_act_t;

endpackage

// File: rtl/src_pick.sv
module src_pick #(
    parameter int N_SRC = 4,
    parameter int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic [N_SRC-1:0] tick,
    input  logic [SEL_W-1:0] sel,
    output logic             adv
);

    logic [N_SRC-1:0] hit;

    for (genvar gi = 0; gi < N_SRC; gi++) begin : g_hit
        assign hit[gi] = tick[gi] && (sel == SEL_W'(gi));
    end

    assign adv = |hit;

endmodule

// File: rtl/last_detect.sv
module last_detect #(
    parameter int CNT_W    = 4,
    parameter int DEC_LAST = 9
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic             bin_mode,
    output logic             at_last,
    output logic             over_dec
);

    localparam logic [CNT_W-1:0] BIN_TOP = '1;
    localparam logic [CNT_W-1:0] DEC_TOP = CNT_W'(DEC_LAST);

    always_comb begin
        if (bin_mode) begin
            at_last  = (cnt == BIN_TOP);
            over_dec = 1'b0;
        end else begin
            at_last  = (cnt == DEC_TOP);
            over_dec = (cnt > DEC_TOP);
        end
    end

endmodule

// File: rtl/count_core.sv
module count_core
    import sel_bd_counter_pkg::*;
#(
    parameter int CNT_W    = 4,
    parameter int DEC_LAST = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    input  logic             bin_mode,
    input  logic             at_last,
    input  logic             over_dec,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);
    localparam logic [CNT_W-1:0] DEC_TOP = CNT_W'(DEC_LAST);

    step_act_t        act;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    // action decode
    always_comb begin
        if (!adv)          act = ACT_HOLD;
        else if (over_dec) act = ACT_CLEAR;
        else if (at_last)  act = ACT_WRAP;
        else               act = ACT_STEP;
    end

    always_comb begin
        unique case (act)
            ACT_HOLD:  cnt_d = cnt_q;
            ACT_STEP:  cnt_d = cnt_q + ONE;
            ACT_WRAP:  cnt_d = '0;
            ACT_CLEAR: cnt_d = '0;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    // outputs
    always_comb begin
        cnt = cnt_q;
    end

    a_r1_reset_zero: assert property (@(posedge clk)
        rst |=> (cnt_q == '0));

    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        !adv |=> (cnt_q == $past(cnt_q)));

    a_r4_bin_step: assert property (@(posedge clk) disable iff (rst)
        (adv && bin_mode && (cnt_q != '1)) |=> (cnt_q == $past(cnt_q) + ONE));

    a_r5_dec_wrap: assert property (@(posedge clk) disable iff (rst)
        (adv && !bin_mode && (cnt_q >= DEC_TOP)) |=> (cnt_q == '0));

    a_r6_dec_bound: assert property (@(posedge clk) disable iff (rst)
        (adv && !bin_mode) |=> (cnt_q <= DEC_TOP));

endmodule

// File: rtl/sel_bd_counter.sv
module sel_bd_counter #(
    parameter int CNT_W    = 4,
    parameter int N_SRC    = 4,
    parameter int DEC_LAST = 9,
    parameter int SEL_W    = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] src_tick,
    input  logic [SEL_W-1:0] src_sel,
    input  logic             bin_mode,
    output logic [CNT_W-1:0] count,
    output logic             terminal
);

    logic adv;
    logic at_last;
    logic over_dec;

    src_pick #(.N_SRC(N_SRC), .SEL_W(SEL_W)) u_pick (
        .tick (src_tick),
        .sel  (src_sel),
        .adv  (adv)
    );

    last_detect #(.CNT_W(CNT_W), .DEC_LAST(DEC_LAST)) u_last (
        .cnt      (count),
        .bin_mode (bin_mode),
        .at_last  (at_last),
        .over_dec (over_dec)
    );

    count_core #(.CNT_W(CNT_W), .DEC_LAST(DEC_LAST)) u_core (
        .clk      (clk),
        .rst      (rst),
        .adv      (adv),
        .bin_mode (bin_mode),
        .at_last  (at_last),
        .over_dec (over_dec),
        .cnt      (count)
    );

    assign terminal = at_last;

    // R2: with every tick low, the count cannot move
    a_r2_no_tick_no_move: assert property (@(posedge clk) disable iff (rst)
        (src_tick == '0) |=> $stable(count));

    a_r7_bin_terminal: assert property (@(posedge clk) disable iff (rst)
        (bin_mode && (count == '1)) |-> terminal);

endmodule

// File: tb/tb_sel_bd_counter.sv
`timescale 1ns/1ps
module tb_sel_bd_counter;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] src_tick = '0;
    logic [1:0] src_sel = '0;
    logic       bin_mode = 1'b1;
    logic [3:0] count;
    logic       terminal;

    int n_cmp = 0;
    int n_bad = 0;
    int model = 0;
    string tag = "R1";
    logic [1:0] prev_sel = '0;
    logic prev_mode = 1'b1;
    bit done = 0;

    always #4 clk = ~clk;

    sel_bd_counter dut (
        .clk(clk), .rst(rst), .src_tick(src_tick), .src_sel(src_sel),
        .bin_mode(bin_mode), .count(count), .terminal(terminal)
    );

    // Call at the falling edge: compare, apply the next inputs, then advance the model.
    task automatic cycle(input logic r, input logic [3:0] t, input logic [1:0] s, input logic m);
        bit q;
        bit tc_exp;
        n_cmp++;
        if (int'(count) != model) begin
            n_bad++;
            $display("FAIL %s count actual=%0d expected=%0d", tag, count, model);
        end
        rst = r; src_tick = t; src_sel = s; bin_mode = m;
        #1;
        tc_exp = m ? (model == 15) : (model == 9);
        n_cmp++;
        if (terminal !== tc_exp) begin
            n_bad++;
            $display("FAIL R7 terminal actual=%0b expected=%0b", terminal, tc_exp);
        end
        q = t[s];
        if (r) begin
            model = 0; tag = "R1";
        end else if (!q) begin
            tag = (t != 0) ? "R2" : "R3";
        end else begin
            if (s != prev_sel || m != prev_mode) tag = "R8";
            else if (m) tag = "R4";
            else if (model > 9) tag = "R6";
            else tag = "R5";
            if (m) model = (model == 15) ? 0 : model + 1;
            else   model = (model >= 9) ? 0 : model + 1;
        end
        prev_sel = s; prev_mode = m;
        @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        cycle(1, 4'hF, 2'd0, 1);
        cycle(1, 4'hF, 2'd3, 0);
        // R4: binary run through the wrap, source A
        for (int i = 0; i < 20; i++) cycle(0, 4'b0001, 2'd0, 1);
        // R3 hold, R2 unselected ticks ignored
        for (int i = 0; i < 4; i++) cycle(0, 4'b0000, 2'd0, 1);
        for (int i = 0; i < 4; i++) cycle(0, 4'b1110, 2'd0, 1);
        // R2: each source in turn
        for (int s = 0; s < 4; s++) begin
            cycle(0, 4'(1 << s), 2'(s), 1);
            cycle(0, ~4'(1 << s), 2'(s), 1);
        end
        // R5: decade run on source C
        cycle(1, 4'h0, 2'd2, 0);
        for (int i = 0; i < 25; i++) cycle(0, 4'b0100, 2'd2, 0);
        // R6: reach 12 in binary, switch to decade
        cycle(1, 4'h0, 2'd3, 1);
        for (int i = 0; i < 12; i++) cycle(0, 4'b1000, 2'd3, 1);
        cycle(0, 4'b0000, 2'd3, 0);
        cycle(0, 4'b1000, 2'd3, 0);
        cycle(0, 4'b1000, 2'd3, 0);
        // R1: reset in the middle of a count
        for (int i = 0; i < 5; i++) cycle(0, 4'b1000, 2'd3, 1);
        cycle(1, 4'hF, 2'd3, 1);
        // random: R8 select/mode changes, mode switches above nine
        for (int i = 0; i < 4000; i++)
            cycle(($urandom_range(0, 99) == 0), 4'($urandom), 2'($urandom),
                  ($urandom_range(0, 3) != 0));
        cycle(0, 4'h0, 2'd0, 1);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule